// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Non-Maskable Bypass

This block gathers interrupt requests from a set of on-chip peripheral sources and from two sources that cannot be masked: a non-maskable interrupt line and an address-break event. Each peripheral source has a sticky status flag and an enable bit. A single global mask bit stands in for the processor's interrupt-disable flag.

At each instruction boundary, which the processor signals, the controller picks the highest-ranked eligible request. It then pulses an accept strobe, presents a vector address for that source, and sets the mask. The mask value from before acceptance is kept in a one-entry holding register, and a return-from-handler strobe copies it back. Stacking of processor state and fetching of the handler belong to the processor.

No port carries a data stream, so there is no valid/ready pair. The boundary and return strobes from the processor and the accept strobe going back are plain single-cycle controls, and nothing at the edge can apply back-pressure. A request that cannot be taken yet stays in its flag or pending latch until it can be taken.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `mask` is 1, `flags` and `enables` are all 0, `accept` is 0, and the holding register holds 0.
- R2: A cycle with `src_req[i]` high sets `flags[i]`. The flag stays set until software clears it. Acceptance does not clear it.
- R3: A write with `wr_sel`=0 ANDs `flags` with `wr_data`: a 0 bit clears the flag and a 1 bit leaves it unchanged. If a request arrives in the same cycle as the clear, the request wins and the flag stays 1.
- R4: A write with `wr_sel`=1 loads `enables` from `wr_data`. A flag whose enable bit is 0 never produces a request and is never accepted.
- R5: Priority is fixed. The non-maskable line ranks first, address break second, and then peripheral source i in ascending order of i. Requests that are not chosen remain pending.
- R6: A peripheral request is taken only while `mask` is 0. While `mask` is 1 it stays held.
- R7: The non-maskable line and address break are each latched when they arrive. They are taken whatever the value of `mask`, and the latch clears only when that source is accepted.
- R8: A request is taken only in a cycle where `insn_done` is high. `accept` is high for exactly that one following cycle.
- R9: `vector` equals VEC_BASE + 2·id. The id is 0 for the non-maskable line, 1 for address break, and 2+i for peripheral source i. It is valid in the cycle `accept` is high.
- R10: On acceptance, `mask` becomes 1 and its previous value is saved in the holding register. A cycle with `rti` high and no acceptance loads `mask` from the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | N_SRC | Peripheral request strobes |
| nmi_req | input | 1 | Non-maskable request strobe |
| abrk_req | input | 1 | Address-break request strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 writes the flags (AND), 1 writes the enables |
| wr_data | input | N_SRC | Write data |
| insn_done | input | 1 | Instruction boundary from the processor |
| rti | input | 1 | Return-from-handler strobe |
| irq_pending | output | 1 | An eligible request exists |
| accept | output | 1 | One-cycle acceptance pulse |
| vector | output | AW | Handler address of the accepted source |
| mask | output | 1 | Global mask bit |
| flags | output | N_SRC | Peripheral status flags |
| enables | output | N_SRC | Peripheral enable bits |

## Verification
Each of the 256 flag patterns of the eight peripheral sources is tried against four enable patterns: all on, alternating bits, the low half only, and the complement of the flags. These patterns show whether the arbiter takes the lowest enabled index and ignores disabled flags, and whether it stays quiet when nothing is enabled. Fixed sequences cover the remaining cases. One piles both non-maskable sources onto pending peripherals while the mask is set, to separate the bypass from the ranking between the two. One sets a flag and clears it in the same cycle. Others hold the boundary strobe low or issue returns in a row, which show that the holding register restores the mask rather than simply clearing it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NMI_ID  = 0;
  localparam int unsigned ABRK_ID = 1;
  localparam int unsigned SRC_ID0 = 2;

  typedef enum logic {
    SEL_FLAGS   = 1'b0,
    SEL_ENABLES = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] enables
);
  import irq_ctrl_pkg::*;

  logic clr_wr, en_wr;
  assign clr_wr = wr_en && (wr_sel == SEL_FLAGS);
  assign en_wr  = wr_en && (wr_sel == SEL_ENABLES);

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i]   <= 1'b0;
        enables[i] <= 1'b0;
      end else begin
        // a new request outranks a clear in the same cycle
        flags[i] <= src_req[i] | (flags[i] & ~(clr_wr & ~wr_data[i]));
        if (en_wr) enables[i] <= wr_data[i];
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 8,
  parameter int IDW   = 4
) (
  input  logic             nmi_pend,
  input  logic             abrk_pend,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] enables,
  input  logic             mask,
  output logic             hit,
  output logic [IDW-1:0]   win_id
);
  import irq_ctrl_pkg::*;

  logic [N_SRC-1:0] live;
  assign live = flags & enables & {N_SRC{~mask}};

  always_comb begin
    hit    = 1'b0;
    win_id = '0;
    // scan downward so the lowest index is the last to write
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        hit    = 1'b1;
        win_id = IDW'(SRC_ID0 + i);
      end
    end
    if (abrk_pend) begin
      hit    = 1'b1;
      win_id = IDW'(ABRK_ID);
    end
    if (nmi_pend) begin
      hit    = 1'b1;
      win_id = IDW'(NMI_ID);
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int             IDW      = 4,
  parameter int             AW       = 16,
  parameter logic [AW-1:0]  VEC_BASE = 16'h0020
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           insn_done,
  input  logic           rti,
  input  logic           nmi_req,
  input  logic           abrk_req,
  input  logic           hit,
  input  logic [IDW-1:0] win_id,
  output logic           nmi_pend,
  output logic           abrk_pend,
  output logic           accept,
  output logic [AW-1:0]  vector,
  output logic           mask,
  output logic           saved_mask
);
  import irq_ctrl_pkg::*;

  logic take;
  assign take = insn_done & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend   <= 1'b0;
      abrk_pend  <= 1'b0;
      accept     <= 1'b0;
      vector     <= '0;
      mask       <= 1'b1;
      saved_mask <= 1'b0;
    end else begin
      nmi_pend  <= nmi_req  | (nmi_pend  & ~(take && win_id == IDW'(NMI_ID)));
      abrk_pend <= abrk_req | (abrk_pend & ~(take && win_id == IDW'(ABRK_ID)));
      accept    <= take;
      if (take) begin
        vector     <= VEC_BASE + (AW'(win_id) << 1);
        saved_mask <= mask;
        mask       <= 1'b1;
      end else if (rti) begin
        mask <= saved_mask;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int            N_SRC    = 8,
  parameter int            AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0020
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             nmi_req,
  input  logic             abrk_req,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [N_SRC-1:0] wr_data,
  input  logic             insn_done,
  input  logic             rti,
  output logic             irq_pending,
  output logic             accept,
  output logic [AW-1:0]    vector,
  output logic             mask,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] enables
);
  localparam int IDW = $clog2(N_SRC + 2);

  logic           hit, nmi_pend, abrk_pend, saved_mask;
  logic [IDW-1:0] win_id;

  irq_src_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .flags(flags), .enables(enables)
  );

  irq_pick #(.N_SRC(N_SRC), .IDW(IDW)) u_pick (
    .nmi_pend(nmi_pend), .abrk_pend(abrk_pend), .flags(flags),
    .enables(enables), .mask(mask), .hit(hit), .win_id(win_id)
  );

  irq_seq #(.IDW(IDW), .AW(AW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti(rti),
    .nmi_req(nmi_req), .abrk_req(abrk_req), .hit(hit), .win_id(win_id),
    .nmi_pend(nmi_pend), .abrk_pend(abrk_pend), .accept(accept),
    .vector(vector), .mask(mask), .saved_mask(saved_mask)
  );

  assign irq_pending = hit;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int            N_SRC    = 8,
  parameter int            AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0020
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             insn_done,
  input logic             accept,
  input logic [AW-1:0]    vector,
  input logic             mask,
  input logic             nmi_pend,
  input logic [N_SRC-1:0] flags
);
  localparam logic [AW-1:0] VEC_SRC0 = VEC_BASE + AW'(4);
  localparam logic [AW-1:0] VEC_END  = VEC_BASE + AW'(2 * (N_SRC + 2));

  // R8
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(insn_done));

  // R10
  accept_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> mask);

  // R6
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vector >= VEC_SRC0) |-> !$past(mask));

  // R9
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (vector[0] == 1'b0 && vector >= VEC_BASE && vector < VEC_END));

  // R5
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vector != VEC_BASE) |-> !$past(nmi_pend));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ((flags & $past(flags)) == $past(flags)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .insn_done(insn_done),
  .accept(accept), .vector(vector), .mask(mask), .nmi_pend(nmi_pend),
  .flags(flags)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int            N    = 8;
  localparam int            AW   = 16;
  localparam logic [15:0]   BASE = 16'h0020;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]  src_req = '0, wr_data = '0;
  logic          nmi_req = 0, abrk_req = 0, wr_en = 0, wr_sel = 0, insn_done = 0, rti = 0;
  logic          irq_pending, accept, mask;
  logic [AW-1:0] vector;
  logic [N-1:0]  flags, enables;
  int            n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .AW(AW), .VEC_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .nmi_req(nmi_req),
    .abrk_req(abrk_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .insn_done(insn_done), .rti(rti), .irq_pending(irq_pending),
    .accept(accept), .vector(vector), .mask(mask), .flags(flags),
    .enables(enables)
  );

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [N-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic pulse_src(logic [N-1:0] p);
    src_req = p; step(); src_req = '0;
  endtask

  task automatic do_rti();
    rti = 1; step(); rti = 0;
  endtask

  task automatic boundary();
    insn_done = 1; step(); insn_done = 0;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 mask", int'(mask), 1);
    chk("R1 flags", int'(flags), 0);
    chk("R1 enables", int'(enables), 0);
    chk("R1 accept", int'(accept), 0);
    rst_n = 1;
    step();
    // R1: holding register is 0, so a return clears the mask
    do_rti();
    chk("R1 saved zero", int'(mask), 0);

    // sweep: R2 R4 R5 R9 R10
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 256; p++) begin
        logic [N-1:0] e;
        int win;
        case (k)
          0: e = 8'hFF;
          1: e = 8'hAA;
          2: e = 8'h0F;
          default: e = ~p[7:0];
        endcase
        wr(1'b0, '0);
        wr(1'b1, e);
        pulse_src(p[7:0]);
        win = -1;
        for (int i = N - 1; i >= 0; i--) if (p[i] && e[i]) win = i;
        chk("R2 flags", int'(flags), p);
        chk("R4 pending", int'(irq_pending), int'(win >= 0));
        boundary();
        chk("R8 accept", int'(accept), int'(win >= 0));
        if (win >= 0) begin
          chk("R9 vector", int'(vector), int'(BASE) + 2 * (2 + win));
          chk("R10 mask set", int'(mask), 1);
          chk("R5 others kept", int'(flags), p);
          step();
          chk("R8 one cycle", int'(accept), 0);
          do_rti();
          chk("R10 restore", int'(mask), 0);
        end
      end
    end

    // R3 set wins over clear in the same cycle, 1 bits keep flags
    wr(1'b0, '0);
    pulse_src(8'h0C);
    src_req = 8'h01; wr_en = 1; wr_sel = 0; wr_data = 8'h08; step();
    src_req = '0; wr_en = 0;
    chk("R3 clear/set", int'(flags), 8'h09);

    // R8 no boundary, no accept
    wr(1'b1, 8'hFF);
    step(); step();
    chk("R8 idle", int'(accept), 0);
    chk("R8 pending", int'(irq_pending), 1);

    // take src0, mask becomes 1 with saved 0
    boundary();
    chk("R9 src0", int'(vector), int'(BASE) + 4);
    // R6 held while masked
    boundary();
    chk("R6 held", int'(accept), 0);
    chk("R6 flag kept", int'(flags), 8'h09);

    // R7 R5 both non-maskables under mask
    nmi_req = 1; abrk_req = 1; step(); nmi_req = 0; abrk_req = 0;
    boundary();
    chk("R7 nmi accept", int'(accept), 1);
    chk("R5 nmi first", int'(vector), int'(BASE));
    boundary();
    chk("R7 abrk accept", int'(accept), 1);
    chk("R5 abrk second", int'(vector), int'(BASE) + 2);
    boundary();
    chk("R7 latch cleared", int'(accept), 0);
    // R10 saved value was 1 (taken under mask), return keeps mask 1
    do_rti();
    chk("R10 restore 1", int'(mask), 1);
    do_rti();
    chk("R10 restore again", int'(mask), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule